// File: doc/BRIEF.md
# Buffered Down-Count Timer Channel

This block is a single timer channel that counts down from a programmed start value. The input clock passes through an 8-bit prescaler and then through a power-of-two divider. Each resulting tick strobe moves the 32-bit working counter down by one while the channel is enabled.

Software never writes the working counter directly. It writes a count buffer and a compare buffer, then raises and lowers a manual-update control bit, which copies both buffers into the working registers. A typical one-shot start takes five writes: load the count buffer, clear the enable, set the update bit, clear the update bit, then set the enable. With reload off, the counter stops at zero. With reload on, it restarts from the count buffer.

Reaching zero sets a status flag, which software clears by writing one to it. The interrupt line is that flag gated by its enable bit. The enable field is five bits wide to match a multi-channel layout, although only one channel is implemented. A level output changes state on compare matches and on the zero crossing, and an invert bit sets its polarity. The live counter value can be read back at any time.

Top module: `dcnt_pwm_timer`

## Requirements
- R1: After reset, every register reads zero, `tout` is low and `irq` is low.
- R2: The prescale field is bits 7:0 at offset 0x00. With value P, a prescaled strobe occurs every P+1 clock cycles. The first strobe comes P+1 cycles after the enable edge.
- R3: The divider select is bits 3:0 at offset 0x04. A value D further divides the strobes by 2^D, and any value above 4 acts as 4. The counter advances only while enable (bit 0 of the control register at 0x08) is set. The prescaler and divider restart whenever enable is clear.
- R4: While manual update (control bit 1) is set, the counter holds and is loaded every cycle from the count buffer (0x0C). The compare register is loaded from the compare buffer (0x10) at the same time. At any other time, writing the buffers does not change the running counter.
- R5: The counter drops by one on each divided strobe while it is nonzero. Its live value reads at 0x14, and writes to 0x14 are ignored.
- R6: With auto-reload (control bit 3) clear, the counter stays at zero once it has reached zero.
- R7: With auto-reload set, the first strobe after the counter reaches zero reloads it from the count buffer.
- R8: The status flag is bit 5 of the interrupt register at 0x44. It is set on the strobe that steps the counter to zero. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` equals the status flag AND enable bit 0 of 0x44. Bits 4:1 of 0x44 are stored and read back without any effect.
- R10: `tout` changes state on each strobe that steps the counter onto the compare value or onto zero. A step that hits both changes it once. Control bit 2 inverts `tout`.
- R11: Prescale, divider, control (including the inert bit 4) and interrupt-enable fields read back as written, masked to their widths. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, registered on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tout | output | 1 | Timer level output |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted prescaler or divider shows up as a wrong value at offset 0x14 within one divided tick period after enable. That is why the stimulus table samples the live count at exact cycle offsets for several prescale and divider settings. A stale working counter or a bad buffer copy shows up as a count that drifts after the next update pulse. A wrong toggle state shows on `tout` at the very strobe that reaches the compare value. A lost or sticky status flag appears on `irq` and at 0x44 in the cycle after the zero step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned DATA_W = 32;

   localparam logic [7:0] OFS_PRE  = 8'h00;
   localparam logic [7:0] OFS_DIV  = 8'h04;
   localparam logic [7:0] OFS_CTRL = 8'h08;
   localparam logic [7:0] OFS_CNTB = 8'h0C;
   localparam logic [7:0] OFS_CMPB = 8'h10;
   localparam logic [7:0] OFS_LIVE = 8'h14;
   localparam logic [7:0] OFS_INT  = 8'h44;

   // control field, LSB = run enable
   typedef struct packed {
      logic dz;
      logic reload;
      logic invert;
      logic upd;
      logic en;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int unsigned PRE_W        = 8,
   parameter int unsigned DIV_W        = 4,
   parameter int unsigned MAX_DIV_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] prescale,
   input  logic [DIV_W-1:0] div_sel,
   output logic             tick
);
   generate
      if (PRE_W < 1 || PRE_W > 16) begin : g_bad_pre
         $error("tmr_tick_gen: PRE_W out of range");
      end
      if (MAX_DIV_LOG2 >= (1 << DIV_W)) begin : g_bad_div
         $error("tmr_tick_gen: MAX_DIV_LOG2 not encodable in DIV_W");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic             pre_hit;

   assign pre_hit = run && (pre_q == prescale);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (!run || pre_hit)
         pre_q <= '0;
      else
         pre_q <= pre_q + PRE_W'(1);
   end

   generate
      if (MAX_DIV_LOG2 == 0) begin : g_nodiv
         logic unused_div;
         assign unused_div = ^div_sel;
         assign tick = pre_hit;
      end else begin : g_div
         localparam int unsigned DC_W = MAX_DIV_LOG2;
         logic [DC_W-1:0]  dcnt_q;
         logic [DC_W-1:0]  mask;
         logic [DIV_W-1:0] eff;

         always_comb begin
            eff  = (div_sel > DIV_W'(MAX_DIV_LOG2)) ? DIV_W'(MAX_DIV_LOG2) : div_sel;
            mask = DC_W'((1 << eff) - 1);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dcnt_q <= '0;
            else if (!run)
               dcnt_q <= '0;
            else if (pre_hit)
               dcnt_q <= dcnt_q + DC_W'(1);
         end

         assign tick = pre_hit && ((dcnt_q & mask) == mask);
      end
   endgenerate
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic             auto_reload,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt_buf,
   input  logic [CNT_W-1:0] cmp_buf,
   output logic [CNT_W-1:0] cnt,
   output logic             zero_evt,
   output logic             match_evt
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
         $error("tmr_count_core: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] nxt;
   logic             step;

   assign step      = run && tick && !load && (cnt != '0);
   assign nxt       = cnt - CNT_W'(1);
   assign zero_evt  = step && (nxt == '0);
   assign match_evt = step && (nxt == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         cmp_q <= '0;
      end else if (load) begin
         cnt   <= cnt_buf;
         cmp_q <= cmp_buf;
      end else if (run && tick) begin
         if (cnt != '0)
            cnt <= nxt;
         else if (auto_reload)
            cnt <= cnt_buf;
      end
   end
endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic zero_evt,
   input  logic match_evt,
   input  logic invert,
   output logic tout
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level_q <= 1'b0;
      else if (zero_evt || match_evt)
         level_q <= ~level_q;
   end

   assign tout = level_q ^ invert;
endmodule

// File: rtl/dcnt_pwm_timer.sv
module dcnt_pwm_timer
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned PRE_W        = 8,
   parameter int unsigned DIV_W        = 4,
   parameter int unsigned MAX_DIV_LOG2 = 4,
   parameter int unsigned NUM_CH       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              tout,
   output logic              irq
);
   localparam int unsigned STAT_BIT = NUM_CH;

   generate
      if (ADDR_W < 7 || ADDR_W > 16) begin : g_bad_addr
         $error("dcnt_pwm_timer: ADDR_W out of range");
      end
      if (NUM_CH < 1 || NUM_CH > 31) begin : g_bad_ch
         $error("dcnt_pwm_timer: NUM_CH out of range");
      end
      if (CNT_W > DATA_W || PRE_W > DATA_W) begin : g_bad_fit
         $error("dcnt_pwm_timer: field wider than data bus");
      end
   endgenerate

   logic [PRE_W-1:0]  pre_q;
   logic [DIV_W-1:0]  div_q;
   ctrl_t             ctrl_q;
   logic [CNT_W-1:0]  cntb_q;
   logic [CNT_W-1:0]  cmpb_q;
   logic [NUM_CH-1:0] int_en_q;
   logic              status_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              tick;
   logic              zero_evt;
   logic              match_evt;

   logic wr_pre, wr_div, wr_ctrl, wr_cntb, wr_cmpb, wr_int;

   assign wr_pre  = bus_we && (bus_addr == ADDR_W'(OFS_PRE));
   assign wr_div  = bus_we && (bus_addr == ADDR_W'(OFS_DIV));
   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_cntb = bus_we && (bus_addr == ADDR_W'(OFS_CNTB));
   assign wr_cmpb = bus_we && (bus_addr == ADDR_W'(OFS_CMPB));
   assign wr_int  = bus_we && (bus_addr == ADDR_W'(OFS_INT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q    <= '0;
         div_q    <= '0;
         ctrl_q   <= '0;
         cntb_q   <= '0;
         cmpb_q   <= '0;
         int_en_q <= '0;
      end else begin
         if (wr_pre)  pre_q    <= bus_wdata[PRE_W-1:0];
         if (wr_div)  div_q    <= bus_wdata[DIV_W-1:0];
         if (wr_ctrl) ctrl_q   <= bus_wdata[CTRL_W-1:0];
         if (wr_cntb) cntb_q   <= bus_wdata[CNT_W-1:0];
         if (wr_cmpb) cmpb_q   <= bus_wdata[CNT_W-1:0];
         if (wr_int)  int_en_q <= bus_wdata[NUM_CH-1:0];
      end
   end

   // a new zero event outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= 1'b0;
      else if (zero_evt)
         status_q <= 1'b1;
      else if (wr_int && bus_wdata[STAT_BIT])
         status_q <= 1'b0;
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_PRE):  bus_rdata = DATA_W'(pre_q);
         ADDR_W'(OFS_DIV):  bus_rdata = DATA_W'(div_q);
         ADDR_W'(OFS_CTRL): bus_rdata = DATA_W'(ctrl_q);
         ADDR_W'(OFS_CNTB): bus_rdata = DATA_W'(cntb_q);
         ADDR_W'(OFS_CMPB): bus_rdata = DATA_W'(cmpb_q);
         ADDR_W'(OFS_LIVE): bus_rdata = DATA_W'(cnt_q);
         ADDR_W'(OFS_INT):  bus_rdata = DATA_W'({status_q, int_en_q});
         default:           bus_rdata = '0;
      endcase
   end

   tmr_tick_gen #(
      .PRE_W(PRE_W), .DIV_W(DIV_W), .MAX_DIV_LOG2(MAX_DIV_LOG2)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.en),
      .prescale(pre_q), .div_sel(div_q), .tick(tick)
   );

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .load(ctrl_q.upd),
      .auto_reload(ctrl_q.reload), .tick(tick),
      .cnt_buf(cntb_q), .cmp_buf(cmpb_q), .cnt(cnt_q),
      .zero_evt(zero_evt), .match_evt(match_evt)
   );

   tmr_out_ctl u_out (
      .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt),
      .match_evt(match_evt), .invert(ctrl_q.invert), .tout(tout)
   );

   assign irq = status_q & int_en_q[0];
endmodule

// File: rtl/dcnt_pwm_timer_chk.sv
module dcnt_pwm_timer_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             upd,
   input logic             reload,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cnt_buf,
   input logic             status,
   input logic             en0,
   input logic             irq
);
   // R3: nothing moves the counter while disabled and not updating
   a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !upd) |=> $stable(cnt));

   // R4: update copies the count buffer
   a_r4_update_loads: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (cnt == $past(cnt_buf)));

   // R5: a strobe on a nonzero count steps down by one
   a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !upd && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

   // R6: one-shot stays at zero
   a_r6_oneshot_rest: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !reload && !upd) |=> (cnt == '0));

   // R8: stepping onto zero sets the flag
   a_r8_status_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !upd && cnt == CNT_W'(1)) |=> status);

   // R9: masked request stays quiet
   a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !en0 |-> !irq);

   // R9: request only with a pending flag
   a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status);
endmodule

bind dcnt_pwm_timer dcnt_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .upd(ctrl_q.upd),
   .reload(ctrl_q.reload), .tick(tick), .cnt(cnt_q), .cnt_buf(cntb_q),
   .status(status_q), .en0(int_en_q[0]), .irq(irq)
);

// File: tb/dcnt_pwm_timer_tb_top.sv
module dcnt_pwm_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tout;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   dcnt_pwm_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tout(tout), .irq(irq)
   );

   // prescale, divider select, start count, cycles after enable, expected live count
   localparam int unsigned NVEC = 7;
   localparam int unsigned VEC [NVEC][5] = '{
      '{0, 0,  10,  4,  6},
      '{1, 0,  10,  7,  7},
      '{0, 2,  20,  9, 18},
      '{2, 1,   5, 13,  3},
      '{0, 0,   3, 10,  0},
      '{3, 0, 100, 40, 90},
      '{0, 9,  50, 33, 48}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      #1;
      bus_we = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic start_run(input int unsigned p, input int unsigned d,
                            input int unsigned n, input int unsigned c,
                            input int unsigned opts);
      wr(8'h00, p);
      wr(8'h04, d);
      wr(8'h0C, n);
      wr(8'h10, c);
      wr(8'h08, 32'h0);
      wr(8'h08, 32'h2);
      wr(8'h08, 32'h0);
      wr(8'h08, 32'h1 | opts);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : main
      logic [31:0] v;

      // R1: reset state
      do_reset();
      foreach (VEC[0][k]) begin end
      peek(8'h00, v); chk("R1 prescale", v, 0);
      peek(8'h04, v); chk("R1 divider", v, 0);
      peek(8'h08, v); chk("R1 control", v, 0);
      peek(8'h0C, v); chk("R1 count buf", v, 0);
      peek(8'h10, v); chk("R1 compare buf", v, 0);
      peek(8'h14, v); chk("R1 live", v, 0);
      peek(8'h44, v); chk("R1 int reg", v, 0);
      chk("R1 tout", {31'b0, tout}, 0);
      chk("R1 irq", {31'b0, irq}, 0);

      // R2 R3 R5 R6: counting cadence table
      for (int i = 0; i < NVEC; i++) begin
         do_reset();
         start_run(VEC[i][0], VEC[i][1], VEC[i][2], 0, 0);
         repeat (VEC[i][3]) @(posedge clk);
         #1;
         peek(8'h14, v);
         chk($sformatf("R2/R3/R5/R6 vector %0d", i), v, VEC[i][4]);
      end

      // R3: clearing enable freezes the counter
      do_reset();
      start_run(0, 0, 100, 0, 0);
      repeat (5) @(posedge clk);
      wr(8'h08, 32'h0);
      peek(8'h14, v); chk("R3 stop value", v, 94);
      repeat (10) @(posedge clk);
      #1;
      peek(8'h14, v); chk("R3 frozen", v, 94);

      // R4: buffers are shadowed until update
      do_reset();
      start_run(0, 0, 50, 0, 0);
      wr(8'h0C, 7);
      repeat (3) @(posedge clk);
      #1;
      peek(8'h14, v); chk("R4 buffer write ignored", v, 46);
      wr(8'h08, 32'h3);
      repeat (3) @(posedge clk);
      #1;
      peek(8'h14, v); chk("R4 hold during update", v, 7);
      wr(8'h08, 32'h1);
      repeat (2) @(posedge clk);
      #1;
      peek(8'h14, v); chk("R4 run after update", v, 5);

      // R5: live value is read-only
      do_reset();
      wr(8'h0C, 30);
      wr(8'h08, 32'h2);
      wr(8'h08, 32'h0);
      wr(8'h14, 32'h1234);
      peek(8'h14, v); chk("R5 live write ignored", v, 30);

      // R7 R9: auto-reload, masked flag
      do_reset();
      start_run(0, 0, 3, 0, 32'h8);
      repeat (5) @(posedge clk);
      #1;
      peek(8'h14, v); chk("R7 reload", v, 2);
      peek(8'h44, v); chk("R9 status with enable off", v, 32'h20);
      chk("R9 irq masked", {31'b0, irq}, 0);

      // R8 R9: flag set, write-one clear
      do_reset();
      wr(8'h44, 32'h1F);
      start_run(0, 0, 4, 0, 0);
      repeat (3) @(posedge clk);
      #1;
      chk("R8 no irq before zero", {31'b0, irq}, 0);
      @(posedge clk);
      #1;
      chk("R9 irq at zero", {31'b0, irq}, 1);
      peek(8'h44, v); chk("R8 status set", v, 32'h3F);
      wr(8'h44, 32'h1F);
      peek(8'h44, v); chk("R8 write zero keeps", v, 32'h3F);
      wr(8'h44, 32'h3E);
      peek(8'h44, v); chk("R8 write one clears", v, 32'h1E);
      chk("R9 irq after clear", {31'b0, irq}, 0);

      // R10: toggle on compare and zero, plain and inverted
      do_reset();
      start_run(0, 0, 5, 2, 0);
      repeat (3) @(posedge clk);
      #1;
      chk("R10 toggle at compare", {31'b0, tout}, 1);
      repeat (2) @(posedge clk);
      #1;
      chk("R10 toggle at zero", {31'b0, tout}, 0);
      do_reset();
      start_run(0, 0, 5, 2, 32'h4);
      repeat (3) @(posedge clk);
      #1;
      chk("R10 inverted at compare", {31'b0, tout}, 0);
      repeat (2) @(posedge clk);
      #1;
      chk("R10 inverted at zero", {31'b0, tout}, 1);

      // R11: field readback and unmapped offsets
      do_reset();
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h08, 32'h0000_0014);
      wr(8'h44, 32'hFFFF_FFFF);
      wr(8'h20, 32'hFFFF_FFFF);
      peek(8'h00, v); chk("R11 prescale mask", v, 32'hFF);
      peek(8'h04, v); chk("R11 divider mask", v, 32'hF);
      peek(8'h08, v); chk("R11 control bits", v, 32'h14);
      peek(8'h44, v); chk("R11 int enables", v, 32'h1F);
      peek(8'h20, v); chk("R11 unmapped", v, 0);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule